// File: doc/BRIEF.md
# Audio Serial Link Output Frame Receiver

This block sits on the codec side of a serial audio link and turns the controller's outbound bit stream into parallel words. It runs on the falling edge of the serial bit clock. A low-to-high change on the sync line marks a new frame. The block then counts the bits that follow and reads the leading 16-bit tag slot. From the tag slot it decides which of the first four 20-bit data slots to pass on. Those slots carry the command address, the command data, and the left and right converter samples.

Each accepted slot leaves the block as a parallel word with a strobe that is one clock long. The strobe rises on the falling edge that samples the slot's last bit. The two command slots are released together as one pair. Each converter word is the upper `DAC_W` bits of its slot. A loopback control input makes the block accept a slot even when the tags say the frame or the slot is invalid.

Top module: `acrx_out_frame_rx`

## Requirements
- R1: While `rst_n` is low, every strobe output is 0 and every word output is 0.
- R2: A frame starts at a falling edge of `bit_clk` where `sync_i` is 1 and was 0 at the previous falling edge. The data bit sampled at that edge is discarded. The next falling edge samples frame bit 0, which is tag bit 15.
- R3: Bits arrive MSB first. The tag slot is 16 bits. It is followed by 20-bit slots, so a frame is 256 bits long. Slot k (k = 1..4) occupies frame bits 16+20(k-1) through 35+20(k-1).
- R4: If tag bit 15 (frame valid, frame bit 0) is 0 and `loop_i` is 0, the frame produces no strobe.
- R5: Tag bits 14, 13, 12 and 11 (frame bits 1 to 4) mark slots 1 to 4 as valid when they are 1. When `loop_i` is 0, a slot whose tag bit is 0 produces no strobe.
- R6: `cmd_vld_o` pulses on the edge that samples frame bit 55. The pulse needs both command tags and the frame valid bit to be 1. It presents slot 1 on `cmd_addr_o` and slot 2 on `cmd_data_o`, each 20 bits wide.
- R7: `dac_l_vld_o` pulses on the edge that samples frame bit 75, and `dac_r_vld_o` pulses on the edge that samples frame bit 95. Each word is the upper `DAC_W` bits (default 18) of its slot, left-justified.
- R8: When `loop_i` is 1 on the edge that samples a slot's last bit, that slot is strobed whatever the frame valid bit and its tag bit hold.
- R9: Tag bits 10 to 0 (frame bits 5 to 15) have no effect on any output.
- R10: If a new frame start arrives before a slot's last bit has been sampled, that slot is never strobed. The new frame is then received normally.
- R11: Every strobe lasts exactly one clock. Each word output holds its value until its own next strobe.
- R12: After all 256 bits of a frame, nothing is strobed until the next frame start, whatever arrives on `sdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync, driven on the rising edge |
| sdata_i | input | 1 | Outbound serial data, MSB first |
| loop_i | input | 1 | Loopback: accept slots regardless of tags |
| cmd_vld_o | output | 1 | Command pair strobe |
| cmd_addr_o | output | SLOT_W | Slot 1 word |
| cmd_data_o | output | SLOT_W | Slot 2 word |
| dac_l_vld_o | output | 1 | Left sample strobe |
| dac_l_o | output | DAC_W | Left sample, upper bits of slot 3 |
| dac_r_vld_o | output | 1 | Right sample strobe |
| dac_r_o | output | DAC_W | Right sample, upper bits of slot 4 |

## Verification
A frame restart and the completion of a slot can fall on the same falling edge. The bench provokes this by raising sync so that the restart is detected exactly on the edge that would sample the last bit of slot 4. At that edge the frame restart must win: there is no right-sample strobe, and the next frame is received in full. A behavioural model built from a bit queue predicts every output on every clock. Explicit strobe counts for each scenario then confirm the restart, the tag gating and the loopback override.

// File: rtl/acrx_pkg.sv
package acrx_pkg;
    localparam int unsigned TAG_BITS   = 16;
    localparam int unsigned SLOT_BITS  = 20;
    localparam int unsigned DATA_SLOTS = 12;
    localparam int unsigned DAC_BITS   = 18;
    localparam int unsigned DAC_CHANS  = 2;

    // Index of each captured slot's tag inside the 4-bit tag vector.
    typedef enum logic [1:0] {
        TAG_CMD_ADDR = 2'd0,
        TAG_CMD_DATA = 2'd1,
        TAG_DAC_L    = 2'd2,
        TAG_DAC_R    = 2'd3
    } cap_tag_e;
endpackage

// File: rtl/acrx_framer.sv
module acrx_framer #(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned CNT_W      = 9
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic             frame_start_o,
    output logic             bit_en_o,
    output logic [CNT_W-1:0] bit_idx_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             sync;
        logic             run;
        logic [CNT_W-1:0] cnt;
    } frm_t;

    frm_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sync     = sync_i;
        frame_start_o = sync_i & ~st_q.sync;
        bit_en_o      = st_q.run & ~frame_start_o;
        bit_idx_o     = st_q.cnt;
        if (frame_start_o) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (bit_en_o) begin
            if (st_q.cnt == LAST_IDX) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the edge after a frame start samples frame bit 0
    assert_first_bit_R2: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_start_o |=> (bit_en_o && bit_idx_o == '0));

    // R3: the bit index stays inside one frame
    assert_idx_range_R3: assert property (@(negedge bit_clk) disable iff (!rst_n)
        bit_en_o |-> (bit_idx_o <= LAST_IDX));

    // R12: after the last frame bit, no bit is taken without a new start
    assert_idle_after_frame_R12: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (bit_en_o && bit_idx_o == LAST_IDX) |=> (!bit_en_o));
endmodule

// File: rtl/acrx_slot_cap.sv
module acrx_slot_cap
    import acrx_pkg::*;
#(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 20,
    parameter int unsigned DAC_W  = 18,
    parameter int unsigned N_CH   = 2,
    parameter int unsigned CNT_W  = 9
) (
    input  logic                        bit_clk,
    input  logic                        rst_n,
    input  logic                        frame_start_i,
    input  logic                        bit_en_i,
    input  logic [CNT_W-1:0]            bit_idx_i,
    input  logic                        sdata_i,
    input  logic                        loop_i,
    output logic                        cmd_vld_o,
    output logic [SLOT_W-1:0]           cmd_addr_o,
    output logic [SLOT_W-1:0]           cmd_data_o,
    output logic [N_CH-1:0]             dac_vld_o,
    output logic [N_CH-1:0][DAC_W-1:0]  dac_o
);
    localparam int unsigned N_TAGS = 2 + N_CH;

    function automatic logic [CNT_W-1:0] slot_end(input int unsigned k);
        return CNT_W'(TAG_W + k * SLOT_W - 1);
    endfunction

    typedef struct packed {
        logic [SLOT_W-1:0]           shift;
        logic                        vf;
        logic [N_TAGS-1:0]           tag;
        logic [SLOT_W-1:0]           addr_hold;
        logic                        cmd_vld;
        logic [SLOT_W-1:0]           cmd_addr;
        logic [SLOT_W-1:0]           cmd_data;
        logic [N_CH-1:0]             dac_vld;
        logic [N_CH-1:0][DAC_W-1:0]  dac;
    } cap_t;

    cap_t st_d, st_q;
    logic [SLOT_W-1:0] word_d;

    always_comb begin
        st_d         = st_q;
        st_d.cmd_vld = 1'b0;
        st_d.dac_vld = '0;
        word_d       = {st_q.shift[SLOT_W-2:0], sdata_i};
        if (frame_start_i) begin
            st_d.vf  = 1'b0;
            st_d.tag = '0;
        end else if (bit_en_i) begin
            st_d.shift = word_d;
            if (bit_idx_i == '0) st_d.vf = sdata_i;
            for (int t = 0; t < N_TAGS; t++) begin
                if (bit_idx_i == CNT_W'(t + 1)) st_d.tag[t] = sdata_i;
            end
            if (bit_idx_i == slot_end(1)) st_d.addr_hold = word_d;
            if (bit_idx_i == slot_end(2) &&
                (loop_i || (st_q.vf && st_q.tag[TAG_CMD_ADDR] && st_q.tag[TAG_CMD_DATA]))) begin
                st_d.cmd_vld  = 1'b1;
                st_d.cmd_addr = st_q.addr_hold;
                st_d.cmd_data = word_d;
            end
            for (int ch = 0; ch < N_CH; ch++) begin
                if (bit_idx_i == slot_end(3 + ch) &&
                    (loop_i || (st_q.vf && st_q.tag[2 + ch]))) begin
                    st_d.dac_vld[ch] = 1'b1;
                    st_d.dac[ch]     = word_d[SLOT_W-1 -: DAC_W];
                end
            end
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_vld_o  = st_q.cmd_vld;
    assign cmd_addr_o = st_q.cmd_addr;
    assign cmd_data_o = st_q.cmd_data;
    assign dac_vld_o  = st_q.dac_vld;
    assign dac_o      = st_q.dac;

    // R11: strobes are single-cycle pulses
    assert_cmd_pulse_R11: assert property (@(negedge bit_clk) disable iff (!rst_n)
        cmd_vld_o |=> !cmd_vld_o);

    // R11: words hold between strobes
    assert_cmd_hold_R11: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !cmd_vld_o |-> ($stable(cmd_addr_o) && $stable(cmd_data_o)));

    // R7: slots end on distinct bits, so at most one strobe per edge
    assert_one_strobe_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
        $onehot0({cmd_vld_o, dac_vld_o}));

    // R4: the command pair needs a valid frame unless loopback forced it
    assert_cmd_gate_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
        cmd_vld_o |-> ($past(loop_i) || st_q.vf));

    // R5: each converter strobe needs its own tag unless loopback forced it
    for (genvar g = 0; g < N_CH; g++) begin : g_dac_chk
        assert_dac_gate_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
            dac_vld_o[g] |-> ($past(loop_i) || (st_q.vf && st_q.tag[2 + g])));
        assert_dac_hold_R11: assert property (@(negedge bit_clk) disable iff (!rst_n)
            !dac_vld_o[g] |-> $stable(dac_o[g]));
    end
endmodule

// File: rtl/acrx_out_frame_rx.sv
module acrx_out_frame_rx
    import acrx_pkg::*;
#(
    parameter int unsigned TAG_W   = TAG_BITS,
    parameter int unsigned SLOT_W  = SLOT_BITS,
    parameter int unsigned N_SLOTS = DATA_SLOTS,
    parameter int unsigned DAC_W   = DAC_BITS
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              sdata_i,
    input  logic              loop_i,
    output logic              cmd_vld_o,
    output logic [SLOT_W-1:0] cmd_addr_o,
    output logic [SLOT_W-1:0] cmd_data_o,
    output logic              dac_l_vld_o,
    output logic [DAC_W-1:0]  dac_l_o,
    output logic              dac_r_vld_o,
    output logic [DAC_W-1:0]  dac_r_o
);
    localparam int unsigned FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

    logic                            frame_start;
    logic                            bit_en;
    logic [CNT_W-1:0]                bit_idx;
    logic [DAC_CHANS-1:0]            dac_vld;
    logic [DAC_CHANS-1:0][DAC_W-1:0] dac_word;

    acrx_framer #(
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) u_framer (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .sync_i        (sync_i),
        .frame_start_o (frame_start),
        .bit_en_o      (bit_en),
        .bit_idx_o     (bit_idx)
    );

    acrx_slot_cap #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .DAC_W  (DAC_W),
        .N_CH   (DAC_CHANS),
        .CNT_W  (CNT_W)
    ) u_cap (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .bit_en_i      (bit_en),
        .bit_idx_i     (bit_idx),
        .sdata_i       (sdata_i),
        .loop_i        (loop_i),
        .cmd_vld_o     (cmd_vld_o),
        .cmd_addr_o    (cmd_addr_o),
        .cmd_data_o    (cmd_data_o),
        .dac_vld_o     (dac_vld),
        .dac_o         (dac_word)
    );

    assign dac_l_vld_o = dac_vld[0];
    assign dac_l_o     = dac_word[0];
    assign dac_r_vld_o = dac_vld[1];
    assign dac_r_o     = dac_word[1];

    // R10: a frame start cuts off a pending strobe on the same edge
    assert_restart_abort_R10: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_start |=> !(cmd_vld_o || dac_l_vld_o || dac_r_vld_o));
endmodule

// File: tb/sim_acrx_out_frame_rx.sv
`timescale 1ns/1ps
module sim_acrx_out_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0, sdata_i = 1'b0, loop_i = 1'b0;
    logic        cmd_vld_o, dac_l_vld_o, dac_r_vld_o;
    logic [19:0] cmd_addr_o, cmd_data_o;
    logic [17:0] dac_l_o, dac_r_o;

    int checks = 0, failures = 0;
    int n_cmd = 0, n_l = 0, n_r = 0;
    bit cmp_en = 1'b0;

    // reference model state
    bit   prv = 1'b0;
    int   pos = -1;
    bit   q[$];
    logic        e_cv = 0, e_lv = 0, e_rv = 0;
    logic [19:0] e_ca = 0, e_cd = 0;
    logic [17:0] e_l = 0, e_r = 0;

    always #2 clk = ~clk;

    acrx_out_frame_rx u0 (
        .bit_clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdata_i(sdata_i), .loop_i(loop_i),
        .cmd_vld_o(cmd_vld_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
        .dac_l_vld_o(dac_l_vld_o), .dac_l_o(dac_l_o),
        .dac_r_vld_o(dac_r_vld_o), .dac_r_o(dac_r_o));

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] take(int from, int w);
        logic [19:0] v = '0;
        for (int i = 0; i < w; i++) v = {v[18:0], q[from + i]};
        return v;
    endfunction

    task automatic model(bit s, bit d, bit l);
        e_cv = 0; e_lv = 0; e_rv = 0;
        if (s && !prv) begin
            pos = 0;
            q.delete();
        end else if (pos >= 0) begin
            q.push_back(d);
            if (q.size() == 56 && (l || (q[0] && q[1] && q[2]))) begin
                e_cv = 1; e_ca = take(16, 20); e_cd = take(36, 20);
            end
            if (q.size() == 76 && (l || (q[0] && q[3]))) begin
                e_lv = 1; e_l = 18'(take(56, 18));
            end
            if (q.size() == 96 && (l || (q[0] && q[4]))) begin
                e_rv = 1; e_r = 18'(take(76, 18));
            end
            if (q.size() == 256) pos = -1;
        end
        prv = s;
    endtask

    task automatic cyc(bit s, bit d, bit l);
        @(posedge clk);
        if (cmp_en) begin
            chk("R6 R11 cmd", {cmd_vld_o, cmd_addr_o, cmd_data_o}, {e_cv, e_ca, e_cd});
            chk("R7 R11 left", {dac_l_vld_o, dac_l_o}, {e_lv, e_l});
            chk("R7 R11 right", {dac_r_vld_o, dac_r_o}, {e_rv, e_r});
        end
        n_cmd += int'(cmd_vld_o); n_l += int'(dac_l_vld_o); n_r += int'(dac_r_vld_o);
        sync_i = s; sdata_i = d; loop_i = l;
        if (rst_n) model(s, d, l);
    endtask

    task automatic clr();
        n_cmd = 0; n_l = 0; n_r = 0;
    endtask

    // tg[3]=slot1 ... tg[0]=slot4
    task automatic frame(bit vf, bit [3:0] tg, bit [10:0] low, bit [19:0] a, bit [19:0] dd,
                         bit [19:0] lw, bit [19:0] rw, int len, bit lp);
        bit fb[256];
        fb[0] = vf;
        for (int i = 0; i < 4; i++) fb[1 + i] = tg[3 - i];
        for (int i = 0; i < 11; i++) fb[5 + i] = low[10 - i];
        for (int i = 0; i < 20; i++) begin
            fb[16 + i] = a[19 - i]; fb[36 + i] = dd[19 - i];
            fb[56 + i] = lw[19 - i]; fb[76 + i] = rw[19 - i];
        end
        for (int i = 96; i < 256; i++) fb[i] = ((i * 7) % 3) == 0;
        for (int c = 0; c < len; c++) cyc(c < 16, (c == 0) ? 1'b0 : fb[c - 1], lp);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) cyc(0, 0, 0);
        // R1: outputs quiet in reset
        chk("R1 strobes", {cmd_vld_o, dac_l_vld_o, dac_r_vld_o}, 0);
        chk("R1 words", {cmd_addr_o, cmd_data_o, dac_l_o}, 0);
        cmp_en = 1'b1;
        rst_n = 1'b1;
        clr();
        for (int i = 0; i < 40; i++) cyc(0, i[0] ^ i[2], 0);
        chk("R2 no frame before sync", n_cmd + n_l + n_r, 0);

        clr();
        frame(1, 4'b1111, 0, 20'hA5C3E, 20'h1234F, 20'hFEDCB, 20'h80001, 256, 0);
        chk("R6 cmd count", n_cmd, 1);
        chk("R11 left single pulse", n_l, 1);
        chk("R11 right single pulse", n_r, 1);
        chk("R2 cmd addr alignment", cmd_addr_o, 20'hA5C3E);
        chk("R6 cmd data", cmd_data_o, 20'h1234F);
        chk("R7 left upper bits", dac_l_o, 18'h3FB72);
        chk("R3 right MSB first", dac_r_o, 18'h20000);

        clr();
        frame(0, 4'b1111, 0, 20'h11111, 20'h22222, 20'h33333, 20'h44444, 256, 0);
        chk("R4 invalid frame strobes", n_cmd + n_l + n_r, 0);

        clr();
        frame(1, 4'b1001, 0, 20'h0F0F0, 20'h55555, 20'h66666, 20'h77777, 256, 0);
        chk("R5 cmd needs both tags", n_cmd, 0);
        chk("R5 left dropped", n_l, 0);
        chk("R5 right kept", n_r, 1);

        clr();
        frame(1, 4'b0110, 0, 20'h0F0F0, 20'h55555, 20'h9ABCD, 20'h77777, 256, 0);
        chk("R6 cmd without slot1 tag", n_cmd, 0);
        chk("R5 left kept", n_l, 1);
        chk("R5 right dropped", n_r, 0);

        clr();
        frame(1, 4'b1111, 11'h7FF, 20'hCAFE1, 20'hBEEF2, 20'h13579, 20'h2468A, 256, 0);
        chk("R9 low tag bits ignored", n_cmd + n_l + n_r, 3);

        clr();
        frame(0, 4'b0000, 0, 20'h31415, 20'h92653, 20'h58979, 20'h32384, 256, 1);
        chk("R8 loopback forces capture", n_cmd + n_l + n_r, 3);

        clr();
        frame(1, 4'b1111, 0, 20'h00ABC, 20'h00DEF, 20'hABCDE, 20'hFFFFF, 96, 0);
        chk("R10 aborted cmd kept", n_cmd, 1);
        chk("R10 aborted left kept", n_l, 1);
        chk("R10 aborted right dropped", n_r, 0);
        clr();
        frame(1, 4'b1111, 0, 20'h10203, 20'h40506, 20'h70809, 20'hA0B0C, 256, 0);
        chk("R10 next frame received", n_cmd + n_l + n_r, 3);

        clr();
        frame(1, 4'b1111, 0, 20'h13131, 20'h24242, 20'h35353, 20'h46464, 256, 0);
        cyc(0, 1, 0);
        clr();
        for (int i = 0; i < 300; i++) cyc(0, i[1] ^ i[3], i[4]);
        chk("R12 idle after frame", n_cmd + n_l + n_r, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule